// File: doc/BRIEF.md
# Bus Mode Control Register

This block is a 16-bit mode register for a bus-mastering network controller. It holds four mode bits. Three of them can be written by the host: burst read enable, burst write enable and extended request hold. Their current values drive level outputs for the downstream bus master. The fourth bit selects double-word I/O. The host cannot write it. The block sets it by itself when it sees a 32-bit write to the register data port. A word from the nonvolatile configuration reader can also load it.

There are two reset inputs with different scope. The asynchronous hard reset clears all four bits. The software reset pulse and the stop condition leave every bit as it is. Host writes to the three writable bits take effect only while the controller reports stopped or suspended. At any other time a write is dropped.

Top module: `bus_mode_ctl`

## Requirements
- R1: While `rst_hw_n` is low, all four mode bits are cleared, so every mode output is 0 and a read of the mode word returns 0.
- R2: A write to the mode offset (default 0x12) while `stopped` or `suspended` is high loads burst read enable from data bit 5, burst write enable from bit 6 and extended request from bit 8. The new values are visible from the next clock edge.
- R3: A write to the mode offset while both `stopped` and `suspended` are low leaves all three writable bits unchanged.
- R4: While `host_rd` is high at the mode offset, `host_rdata` shows burst read enable on bit 5, burst write enable on bit 6, double-word I/O on bit 7 and extended request on bit 8, with all other bits 0. At any other time `host_rdata` is 0.
- R5: Host writes never change the double-word I/O bit, whatever value data bit 7 carries.
- R6: A write with `host_dword` high to offset 0x10 sets the double-word I/O bit at the next clock edge. A write there with `host_dword` low does not set it, and neither does a read.
- R7: Once set, the double-word I/O bit stays set until a hard reset or a configuration load.
- R8: A `cfg_load` pulse copies `cfg_dword` into the double-word I/O bit, which can set it or clear it. If a configuration load and an auto-detect write happen in the same cycle, the load value wins.
- R9: Pulsing `sw_reset` or raising `stopped` changes none of the four bits.
- R10: `mode_burst_rd`, `mode_burst_wr`, `mode_ext_req` and `mode_dword` always match the register bits that the mode word reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_hw_n | input | 1 | Asynchronous hard reset, active low |
| sw_reset | input | 1 | Software reset pulse; has no effect on the mode bits |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Byte offset from the I/O base |
| host_dword | input | 1 | Access width: 1 = 32-bit, 0 = 16-bit |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data |
| stopped | input | 1 | Controller stopped status |
| suspended | input | 1 | Controller suspended status |
| cfg_load | input | 1 | Configuration load strobe |
| cfg_dword | input | 1 | Double-word I/O value from the configuration reader |
| mode_burst_rd | output | 1 | Burst read enable level |
| mode_burst_wr | output | 1 | Burst write enable level |
| mode_ext_req | output | 1 | Extended request hold level |
| mode_dword | output | 1 | Double-word I/O mode level |

## Verification
Some rules can be written as properties, and the assertions check them on every cycle:
- the writable bits hold while the write lock is active, and they hold across a software reset;
- the double-word bit is sticky, and it never rises without a data-port hit or a load;
- a configuration load has priority over auto-detect;
- the level outputs agree with the read word.

Other behaviour only the bench scenarios can show. The full sweep of data patterns against the four lock states shows that each field sits at its stated position and that every other bit reads as 0. Separate sequences show that 16-bit data-port writes and reads leave the double-word bit unchanged, and that a hard reset in the middle of a run clears a fully set register.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

   typedef struct packed {
      logic ext_req;
      logic dword;
      logic burst_wr;
      logic burst_rd;
   } mode_bits_t;

   localparam int MODE_FIELDS = 4;

endpackage

// File: rtl/bmc_write_gate.sv
module bmc_write_gate #(
   parameter int ADDR_W   = 5,
   parameter int MODE_OFS = 18
) (
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              stopped,
   input  logic              suspended,
   output logic              wr_accept
);

   localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_OFS);

   logic hit;
   logic unlocked;

   assign hit       = host_wr && (host_addr == MODE_A);
   assign unlocked  = stopped || suspended;
   assign wr_accept = hit && unlocked;

endmodule

// File: rtl/bmc_dword_track.sv
module bmc_dword_track #(
   parameter int ADDR_W    = 5,
   parameter int DPORT_OFS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_dword,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              cfg_load,
   input  logic              cfg_dword,
   output logic              dword_q
);

   localparam logic [ADDR_W-1:0] DPORT_A = ADDR_W'(DPORT_OFS);

   logic auto_hit;

   assign auto_hit = host_wr && host_dword && (host_addr == DPORT_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dword_q <= 1'b0;
      else if (cfg_load) dword_q <= cfg_dword;
      else if (auto_hit) dword_q <= 1'b1;
   end

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (dword_q && !cfg_load) |=> dword_q);

   a_r6_auto_set: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_dword && host_addr == DPORT_A && !cfg_load) |=> dword_q);

   a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!dword_q && !cfg_load && !(host_wr && host_dword)) |=> !dword_q);

   a_r8_cfg_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> (dword_q == $past(cfg_dword)));

endmodule

// File: rtl/bmc_read_mux.sv
module bmc_read_mux #(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 16,
   parameter int MODE_OFS = 18,
   parameter int POS_BRD  = 5,
   parameter int POS_BWR  = 6,
   parameter int POS_DW   = 7,
   parameter int POS_XRQ  = 8,
   parameter int RD_REG   = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_rd,
   input  logic [ADDR_W-1:0]   host_addr,
   input  bmc_pkg::mode_bits_t bits,
   output logic [DATA_W-1:0]   rdata
);

   localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_OFS);

   logic              sel;
   logic [DATA_W-1:0] word;

   assign sel = host_rd && (host_addr == MODE_A);

   always_comb begin
      word          = '0;
      word[POS_BRD] = bits.burst_rd;
      word[POS_BWR] = bits.burst_wr;
      word[POS_DW]  = bits.dword;
      word[POS_XRQ] = bits.ext_req;
   end

   generate
      if (RD_REG == 0) begin : g_comb
         assign rdata = sel ? word : '0;
      end else begin : g_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   rdata_q <= '0;
            else if (sel) rdata_q <= word;
            else          rdata_q <= '0;
         end
         assign rdata = rdata_q;
      end
   endgenerate

endmodule

// File: rtl/bus_mode_ctl.sv
module bus_mode_ctl #(
   parameter int ADDR_W    = 5,
   parameter int DATA_W    = 16,
   parameter int MODE_OFS  = 18,
   parameter int DPORT_OFS = 16,
   parameter int POS_BRD   = 5,
   parameter int POS_BWR   = 6,
   parameter int POS_DW    = 7,
   parameter int POS_XRQ   = 8,
   parameter int RD_REG    = 0
) (
   input  logic              clk,
   input  logic              rst_hw_n,
   input  logic              sw_reset,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_dword,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              stopped,
   input  logic              suspended,
   input  logic              cfg_load,
   input  logic              cfg_dword,
   output logic              mode_burst_rd,
   output logic              mode_burst_wr,
   output logic              mode_ext_req,
   output logic              mode_dword
);

   localparam logic [ADDR_W-1:0] MODE_A   = ADDR_W'(MODE_OFS);
   localparam int                ADDR_SPAN = 1 << ADDR_W;

   generate
      if (ADDR_W < 5)
         $error("bus_mode_ctl: ADDR_W too small for the data port offset");
      if (MODE_OFS >= ADDR_SPAN || DPORT_OFS >= ADDR_SPAN)
         $error("bus_mode_ctl: offset outside address space");
      if (MODE_OFS == DPORT_OFS)
         $error("bus_mode_ctl: mode and data port offsets collide");
      if (POS_BRD >= DATA_W || POS_BWR >= DATA_W || POS_DW >= DATA_W || POS_XRQ >= DATA_W)
         $error("bus_mode_ctl: field position beyond data width");
      if (POS_BRD == POS_BWR || POS_BRD == POS_DW || POS_BRD == POS_XRQ ||
          POS_BWR == POS_DW  || POS_BWR == POS_XRQ || POS_DW == POS_XRQ)
         $error("bus_mode_ctl: field positions overlap");
      if (RD_REG != 0 && RD_REG != 1)
         $error("bus_mode_ctl: RD_REG must be 0 or 1");
   endgenerate

   logic                wr_ok;
   logic                brd_q;
   logic                bwr_q;
   logic                xrq_q;
   logic                dw_q;
   bmc_pkg::mode_bits_t bits;
   logic                wdata_unused;

   assign wdata_unused = ^host_wdata;

   bmc_write_gate #(
      .ADDR_W   (ADDR_W),
      .MODE_OFS (MODE_OFS)
   ) u_gate (
      .host_wr   (host_wr),
      .host_addr (host_addr),
      .stopped   (stopped),
      .suspended (suspended),
      .wr_accept (wr_ok)
   );

   always_ff @(posedge clk or negedge rst_hw_n) begin
      if (!rst_hw_n) begin
         brd_q <= 1'b0;
         bwr_q <= 1'b0;
         xrq_q <= 1'b0;
      end else if (wr_ok) begin
         brd_q <= host_wdata[POS_BRD];
         bwr_q <= host_wdata[POS_BWR];
         xrq_q <= host_wdata[POS_XRQ];
      end
   end

   bmc_dword_track #(
      .ADDR_W    (ADDR_W),
      .DPORT_OFS (DPORT_OFS)
   ) u_dword (
      .clk        (clk),
      .rst_n      (rst_hw_n),
      .host_wr    (host_wr),
      .host_dword (host_dword),
      .host_addr  (host_addr),
      .cfg_load   (cfg_load),
      .cfg_dword  (cfg_dword),
      .dword_q    (dw_q)
   );

   assign bits.burst_rd = brd_q;
   assign bits.burst_wr = bwr_q;
   assign bits.dword    = dw_q;
   assign bits.ext_req  = xrq_q;

   bmc_read_mux #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .MODE_OFS (MODE_OFS),
      .POS_BRD  (POS_BRD),
      .POS_BWR  (POS_BWR),
      .POS_DW   (POS_DW),
      .POS_XRQ  (POS_XRQ),
      .RD_REG   (RD_REG)
   ) u_rmux (
      .clk       (clk),
      .rst_n     (rst_hw_n),
      .host_rd   (host_rd),
      .host_addr (host_addr),
      .bits      (bits),
      .rdata     (host_rdata)
   );

   assign mode_burst_rd = brd_q;
   assign mode_burst_wr = bwr_q;
   assign mode_ext_req  = xrq_q;
   assign mode_dword    = dw_q;

   a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_hw_n)
      (!stopped && !suspended) |=> $stable({mode_burst_rd, mode_burst_wr, mode_ext_req}));

   a_r2_write_load: assert property (@(posedge clk) disable iff (!rst_hw_n)
      (host_wr && host_addr == MODE_A && (stopped || suspended)) |=>
      ({mode_ext_req, mode_burst_wr, mode_burst_rd} ==
       $past({host_wdata[POS_XRQ], host_wdata[POS_BWR], host_wdata[POS_BRD]})));

   a_r9_swrst_keep: assert property (@(posedge clk) disable iff (!rst_hw_n)
      (sw_reset && !host_wr && !cfg_load) |=>
      $stable({mode_burst_rd, mode_burst_wr, mode_ext_req, mode_dword}));

   generate
      if (RD_REG == 0) begin : g_chk_comb
         a_r10_out_match: assert property (@(posedge clk) disable iff (!rst_hw_n)
            (host_rd && host_addr == MODE_A) |->
            (host_rdata[POS_BRD] == mode_burst_rd && host_rdata[POS_BWR] == mode_burst_wr &&
             host_rdata[POS_DW] == mode_dword && host_rdata[POS_XRQ] == mode_ext_req));
      end
   endgenerate

endmodule

// File: tb/test_bus_mode_ctl.sv
`timescale 1ns/1ps
module test_bus_mode_ctl;

   localparam logic [4:0] MODE_A  = 5'h12;
   localparam logic [4:0] DPORT_A = 5'h10;

   logic        clk = 1'b0;
   logic        rst_hw_n = 1'b0;
   logic        sw_reset = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [4:0]  host_addr = '0;
   logic        host_dword = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        stopped = 1'b0;
   logic        suspended = 1'b0;
   logic        cfg_load = 1'b0;
   logic        cfg_dword = 1'b0;
   logic        mode_burst_rd, mode_burst_wr, mode_ext_req, mode_dword;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic m_brd = 1'b0, m_bwr = 1'b0, m_xrq = 1'b0, m_dw = 1'b0;

   always #10 clk = ~clk;

   bus_mode_ctl i_bus_mode_ctl (
      .clk(clk), .rst_hw_n(rst_hw_n), .sw_reset(sw_reset),
      .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
      .host_dword(host_dword), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .stopped(stopped), .suspended(suspended),
      .cfg_load(cfg_load), .cfg_dword(cfg_dword),
      .mode_burst_rd(mode_burst_rd), .mode_burst_wr(mode_burst_wr),
      .mode_ext_req(mode_ext_req), .mode_dword(mode_dword)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_word();
      logic [15:0] w = '0;
      w[5] = m_brd; w[6] = m_bwr; w[7] = m_dw; w[8] = m_xrq;
      return w;
   endfunction

   task automatic check_state(input string req);
      @(negedge clk);
      host_rd = 1'b1; host_addr = MODE_A;
      #1;
      chk(req, host_rdata, exp_word());
      chk({req, " R10 outputs"}, {12'h0, mode_ext_req, mode_dword, mode_burst_wr, mode_burst_rd},
          {12'h0, m_xrq, m_dw, m_bwr, m_brd});
      host_rd = 1'b0;
   endtask

   task automatic do_write(input logic [4:0] a, input logic dw, input logic [15:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_dword = dw; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0; host_dword = 1'b0; host_wdata = '0;
   endtask

   task automatic do_cfg(input logic v, input logic with_auto);
      @(negedge clk);
      cfg_load = 1'b1; cfg_dword = v;
      if (with_auto) begin
         host_wr = 1'b1; host_addr = DPORT_A; host_dword = 1'b1; host_wdata = 16'hABCD;
      end
      @(negedge clk);
      cfg_load = 1'b0; host_wr = 1'b0; host_dword = 1'b0; host_wdata = '0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check_state("R1 reset");
      rst_hw_n = 1'b1;
      check_state("R1 after release");

      // R4: idle read data is zero
      @(negedge clk);
      host_rd = 1'b0; host_addr = MODE_A; #1;
      chk("R4 no strobe", host_rdata, 16'h0);
      host_rd = 1'b1; host_addr = DPORT_A; #1;
      chk("R4 other offset", host_rdata, 16'h0);
      host_rd = 1'b0;

      // R2 R3 R5: sweep patterns against lock states
      for (int lk = 0; lk < 4; lk++) begin
         for (int p = 0; p < 16; p++) begin
            logic [15:0] d;
            stopped   = lk[0];
            suspended = lk[1];
            d = 16'(p * 16'h1357) ^ 16'hA5A5;
            d[5] = p[0]; d[6] = p[1]; d[7] = p[2]; d[8] = p[3];
            do_write(MODE_A, p[0], d);
            if (lk != 0) begin
               m_brd = p[0]; m_bwr = p[1]; m_xrq = p[3];
            end
            check_state(lk != 0 ? "R2 R5 unlocked write" : "R3 R5 locked write");
         end
      end
      stopped = 1'b1; suspended = 1'b0;
      do_write(MODE_A, 1'b0, 16'h0160);
      m_brd = 1'b1; m_bwr = 1'b1; m_xrq = 1'b1;
      check_state("R2 set all");

      // R6: non-triggering accesses
      do_write(DPORT_A, 1'b0, 16'hFFFF);
      check_state("R6 16-bit dport write");
      @(negedge clk);
      host_rd = 1'b1; host_dword = 1'b1; host_addr = DPORT_A;
      @(negedge clk);
      host_rd = 1'b0; host_dword = 1'b0;
      check_state("R6 dport read");
      do_write(MODE_A, 1'b1, 16'h01E0);
      check_state("R5 32-bit mode write bit7");

      // R6: trigger
      do_write(DPORT_A, 1'b1, 16'h0000);
      m_dw = 1'b1;
      check_state("R6 auto set");

      // R7: sticky through host writes
      do_write(MODE_A, 1'b0, 16'h0000);
      m_brd = 1'b0; m_bwr = 1'b0; m_xrq = 1'b0;
      check_state("R7 R5 write bit7 zero");
      do_write(MODE_A, 1'b0, 16'h0140);
      m_bwr = 1'b1; m_xrq = 1'b1;
      check_state("R7 still set");

      // R9: software reset and stop
      stopped = 1'b0;
      @(negedge clk); sw_reset = 1'b1;
      @(negedge clk); sw_reset = 1'b0;
      check_state("R9 sw_reset");
      @(negedge clk); stopped = 1'b1;
      @(negedge clk); stopped = 1'b0;
      check_state("R9 stop toggle");

      // R8: configuration loads
      do_cfg(1'b1, 1'b0);
      check_state("R8 load one");
      do_cfg(1'b0, 1'b0);
      m_dw = 1'b0;
      check_state("R8 load zero clears");
      do_cfg(1'b0, 1'b1);
      check_state("R8 load beats auto");
      do_cfg(1'b1, 1'b0);
      m_dw = 1'b1;
      check_state("R8 load sets");

      // R1: hard reset mid-run
      @(negedge clk); rst_hw_n = 1'b0;
      m_brd = 1'b0; m_bwr = 1'b0; m_xrq = 1'b0; m_dw = 1'b0;
      check_state("R1 mid-run reset");
      @(negedge clk); rst_hw_n = 1'b1;
      check_state("R1 after second release");

      done = 1'b1;
      finish_run();
   end

endmodule